// File: doc/BRIEF.md
# Shared-Buffer Word Validity Tracker

This block sits beside a shared word buffer that one producer fills and several consumers drain. It keeps one validity flag per stored word, arranged as a grid of rows and columns that mirrors the buffer's layout. A producer write raises the flag of the word it stores. A consumer asks before reading and is either granted or told to hold. The flags start at zero, and a single clear command returns them all to zero before the buffer is reused as a channel.

A consumer request names a row, a starting column and a shape. The shape is one word, a run of consecutive columns along the row, or a three-by-three patch whose top-left corner is the named word. The whole shape is judged in the same cycle. One missing word anywhere in it blocks the entire access. Two read ports are judged independently and in parallel, in the same cycle as a write. A consumer that sees hold keeps its request up, and the grant appears in the first cycle in which every word it asked for has become valid.

Top module: `vt_tracker`

## Requirements
- R1: After reset every flag is 0, so any request is answered with hold.
- R2: A clear zeroes every flag on the next clock edge, whatever write address is presented. A clear wins over a write in the same cycle.
- R3: A write without clear sets the addressed flag at the clock edge, and the flag is visible from the next cycle. A read of the same word in the write's own cycle still sees the old value.
- R4: Read shape codes are 00 single word, 01 run, 10 window and 11 reserved. A single-word request is granted exactly when its flag is 1 and held otherwise. The reserved code is always held.
- R5: A run request covers columns start to stop inclusive on one row, up to the full row width of 16 columns. It is granted only if every flag in the run is 1. Flags outside the run have no effect.
- R6: A run request whose stop column is below its start column is held.
- R7: A window request covers rows row..row+2 and columns col..col+2. It is held if any of the nine flags is 0.
- R8: A window that would extend past the last row or the last column is held.
- R9: Grant and hold are combinational in the request. With a request exactly one of them is high, and with no request both are low. The two read ports are judged independently.
- R10: Without a clear, no flag ever falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Zero every flag |
| wr_en_i | input | 1 | Producer write strobe |
| wr_row_i | input | 3 | Row of the written word |
| wr_col_i | input | 4 | Column of the written word |
| rd0_req_i | input | 1 | Port 0 request |
| rd0_mode_i | input | 2 | Port 0 shape code |
| rd0_row_i | input | 3 | Port 0 row (window: top row) |
| rd0_col_i | input | 4 | Port 0 start column |
| rd0_stop_i | input | 4 | Port 0 last column of a run |
| rd0_grant_o | output | 1 | Port 0 all requested words valid |
| rd0_hold_o | output | 1 | Port 0 must wait |
| rd1_req_i | input | 1 | Port 1 request |
| rd1_mode_i | input | 2 | Port 1 shape code |
| rd1_row_i | input | 3 | Port 1 row (window: top row) |
| rd1_col_i | input | 4 | Port 1 start column |
| rd1_stop_i | input | 4 | Port 1 last column of a run |
| rd1_grant_o | output | 1 | Port 1 all requested words valid |
| rd1_hold_o | output | 1 | Port 1 must wait |

## Verification
The assertions assume that request fields are stable between clock edges and that the row and column inputs are known whenever their strobes are high. Malformed shapes, such as a reversed run, a window that crosses an edge or the reserved code, are legal input, and the block must answer them with hold. The stimulus draws every field over its full range, including reversed runs and windows that cross an edge. It keeps clears rare so that flags build up and grants actually occur. Directed cases cover a clear racing a write and a read colliding with a write to the same word.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    VT_SINGLE = 2'b00,
    VT_RUN    = 2'b01,
    VT_WINDOW = 2'b10,
    VT_RSVD   = 2'b11
  } vt_shape_e;

  localparam int VT_WIN = 3;
endpackage

// File: rtl/vt_array.sv
module vt_array #(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           wr_en_i,
  input  logic [ROW_W-1:0]               wr_row_i,
  input  logic [COL_W-1:0]               wr_col_i,
  output logic [ROWS-1:0][COLS-1:0]      flags_o
);
  logic [ROWS-1:0][COLS-1:0] flags_q, flags_d;
  logic                      upd_en;

  always_comb begin
    flags_d = flags_q;
    if (clr_i) begin
      flags_d = '0;
    end else if (wr_en_i) begin
      flags_d[wr_row_i][wr_col_i] = 1'b1;
    end
  end

  assign upd_en = clr_i | wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (flags_q == '0));

  assert_write_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i) |=> flags_q[$past(wr_row_i)][$past(wr_col_i)]);

  assert_no_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (($past(flags_q) & ~flags_q) == '0));
endmodule

// File: rtl/vt_check.sv
module vt_check
  import vt_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ROWS-1:0][COLS-1:0] flags_i,
  input  logic                      req_i,
  input  logic [1:0]                shape_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic [COL_W-1:0]          col_i,
  input  logic [COL_W-1:0]          stop_i,
  output logic                      grant_o,
  output logic                      hold_o
);
  vt_shape_e         shape;
  int                col_lo, col_hi, row_lo, row_hi;
  logic              malformed;
  logic [COLS-1:0]   col_sel;
  logic [ROWS-1:0]   row_sel;
  logic              any_missing;
  logic              all_ok;

  assign shape = vt_shape_e'(shape_i);

  // Extent of the requested shape and its legality
  always_comb begin
    col_lo    = int'(col_i);
    col_hi    = col_lo;
    row_lo    = int'(row_i);
    row_hi    = row_lo;
    malformed = 1'b0;
    case (shape)
      VT_SINGLE: malformed = 1'b0;
      VT_RUN: begin
        col_hi    = int'(stop_i);
        malformed = (col_hi < col_lo);
      end
      VT_WINDOW: begin
        col_hi    = col_lo + VT_WIN - 1;
        row_hi    = row_lo + VT_WIN - 1;
        malformed = (col_hi >= COLS) || (row_hi >= ROWS);
      end
      default: malformed = 1'b1;
    endcase
  end

  // Row and column selects of the flags that take part
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_sel[c] = (c >= col_lo) && (c <= col_hi);
    end
    for (int r = 0; r < ROWS; r++) begin
      row_sel[r] = (r >= row_lo) && (r <= row_hi);
    end
  end

  // Any selected flag still at zero blocks the whole access
  always_comb begin
    any_missing = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (row_sel[r] && col_sel[c] && !flags_i[r][c]) begin
          any_missing = 1'b1;
        end
      end
    end
  end

  assign all_ok  = !malformed && !any_missing;
  assign grant_o = req_i && all_ok;
  assign hold_o  = req_i && !all_ok;

  assert_one_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> (grant_o ^ hold_o));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (!grant_o && !hold_o));

  assert_single_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && shape_i == 2'b00) |-> flags_i[row_i][col_i]);

  assert_rsvd_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && shape_i == 2'b11) |-> hold_o);

  assert_run_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && shape_i == 2'b01) |-> (flags_i[row_i][col_i] && flags_i[row_i][stop_i]));

  assert_run_reversed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && shape_i == 2'b01 && stop_i < col_i) |-> hold_o);

  assert_window_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && shape_i == 2'b10 &&
     ((int'(row_i) + VT_WIN > ROWS) || (int'(col_i) + VT_WIN > COLS))) |-> hold_o);

  assert_window_corner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && shape_i == 2'b10) |-> flags_i[row_i][col_i]);
endmodule

// File: rtl/vt_tracker.sv
module vt_tracker
  import vt_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 16,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic             rd0_req_i,
  input  logic [1:0]       rd0_mode_i,
  input  logic [ROW_W-1:0] rd0_row_i,
  input  logic [COL_W-1:0] rd0_col_i,
  input  logic [COL_W-1:0] rd0_stop_i,
  output logic             rd0_grant_o,
  output logic             rd0_hold_o,
  input  logic             rd1_req_i,
  input  logic [1:0]       rd1_mode_i,
  input  logic [ROW_W-1:0] rd1_row_i,
  input  logic [COL_W-1:0] rd1_col_i,
  input  logic [COL_W-1:0] rd1_stop_i,
  output logic             rd1_grant_o,
  output logic             rd1_hold_o
);
  localparam int NRD = 2;

  logic [ROWS-1:0][COLS-1:0] flags;
  logic [NRD-1:0]            req, grant, hold;
  logic [NRD-1:0][1:0]       mode;
  logic [NRD-1:0][ROW_W-1:0] row;
  logic [NRD-1:0][COL_W-1:0] col, stop;

  assign req  = {rd1_req_i,  rd0_req_i};
  assign mode = {rd1_mode_i, rd0_mode_i};
  assign row  = {rd1_row_i,  rd0_row_i};
  assign col  = {rd1_col_i,  rd0_col_i};
  assign stop = {rd1_stop_i, rd0_stop_i};

  vt_array #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) array_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .wr_en_i  (wr_en_i),
    .wr_row_i (wr_row_i),
    .wr_col_i (wr_col_i),
    .flags_o  (flags)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    vt_check #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) check_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flags),
      .req_i   (req[p]),
      .shape_i (mode[p]),
      .row_i   (row[p]),
      .col_i   (col[p]),
      .stop_i  (stop[p]),
      .grant_o (grant[p]),
      .hold_o  (hold[p])
    );
  end

  assign rd0_grant_o = grant[0];
  assign rd0_hold_o  = hold[0];
  assign rd1_grant_o = grant[1];
  assign rd1_hold_o  = hold[1];

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0));
endmodule

// File: tb/vt_tracker_tb_top.sv
`timescale 1ns/1ps
module vt_tracker_tb_top;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int RW   = 3;
  localparam int CW   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, clr, wr_en;
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic          r0_req, r1_req;
  logic [1:0]    r0_mode, r1_mode;
  logic [RW-1:0] r0_row, r1_row;
  logic [CW-1:0] r0_col, r1_col, r0_stop, r1_stop;
  logic          r0_grant, r0_hold, r1_grant, r1_hold;

  logic [COLS-1:0] mdl [ROWS];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vt_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_row_i(wr_row), .wr_col_i(wr_col),
    .rd0_req_i(r0_req), .rd0_mode_i(r0_mode), .rd0_row_i(r0_row),
    .rd0_col_i(r0_col), .rd0_stop_i(r0_stop),
    .rd0_grant_o(r0_grant), .rd0_hold_o(r0_hold),
    .rd1_req_i(r1_req), .rd1_mode_i(r1_mode), .rd1_row_i(r1_row),
    .rd1_col_i(r1_col), .rd1_stop_i(r1_stop),
    .rd1_grant_o(r1_grant), .rd1_hold_o(r1_hold)
  );

  function automatic bit exp_ok(input logic [1:0] m, input int r, input int c, input int s);
    case (m)
      2'b00: return mdl[r][c];
      2'b01: begin
        if (s < c) return 0;
        for (int k = c; k <= s; k++) if (!mdl[r][k]) return 0;
        return 1;
      end
      2'b10: begin
        if (r + 3 > ROWS || c + 3 > COLS) return 0;
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++)
            if (!mdl[r+i][c+j]) return 0;
        return 1;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic req, input logic [1:0] m,
                     input int r, input int c, input int s,
                     input logic g, input logic h);
    logic ok;
    logic [1:0] exp, act;
    ok  = exp_ok(m, r, c, s);
    exp = {req && ok, req && !ok};
    act = {g, h};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s grant/hold actual=%b expected=%b (mode=%b row=%0d col=%0d stop=%0d)",
               tag, act, exp, m, r, c, s);
    end
  endtask

  // Check both ports now, then let one clock edge pass and update the model.
  task automatic cycle(input string t0, input string t1);
    #5;
    chk(t0, r0_req, r0_mode, r0_row, r0_col, r0_stop, r0_grant, r0_hold);
    chk(t1, r1_req, r1_mode, r1_row, r1_col, r1_stop, r1_grant, r1_hold);
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (clr) for (int i = 0; i < ROWS; i++) mdl[i] = '0;
      else if (wr_en) mdl[wr_row][wr_col] = 1'b1;
    end
  endtask

  task automatic idle();
    clr = 0; wr_en = 0; wr_row = '0; wr_col = '0;
    r0_req = 0; r0_mode = 0; r0_row = '0; r0_col = '0; r0_stop = '0;
    r1_req = 0; r1_mode = 0; r1_row = '0; r1_col = '0; r1_stop = '0;
  endtask

  task automatic rd0(input logic [1:0] m, input int r, input int c, input int s);
    r0_req = 1; r0_mode = m; r0_row = RW'(r); r0_col = CW'(c); r0_stop = CW'(s);
  endtask

  task automatic wr(input int r, input int c);
    wr_en = 1; wr_row = RW'(r); wr_col = CW'(c);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1DEA5));
    for (int i = 0; i < ROWS; i++) mdl[i] = '0;
    idle();
    rst_n = 0;
    // R1: during reset a request finds every flag at zero
    rd0(2'b00, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    cycle("R1", "R9");
    rst_n = 1;
    #1;
    cycle("R1", "R9");

    // R3: write and read the same word in one cycle: old value seen
    idle(); wr(2, 3); rd0(2'b00, 2, 3, 0);
    cycle("R3", "R9");
    idle(); rd0(2'b00, 2, 3, 0);
    cycle("R3", "R9");

    // R2: clear wins over a simultaneous write
    idle(); clr = 1; wr(1, 1);
    cycle("R2", "R9");
    idle(); rd0(2'b00, 1, 1, 0); r1_req = 1; r1_mode = 2'b00; r1_row = 3'd2; r1_col = 4'd3;
    cycle("R2", "R2");

    // R5: fill row 4 except column 5; run 6..15 ignores the hole
    for (int c = 0; c < COLS; c++) begin
      idle();
      if (c != 5) wr(4, c);
      cycle("R3", "R9");
    end
    idle(); rd0(2'b01, 4, 6, 15);
    cycle("R5", "R9");
    idle(); rd0(2'b01, 4, 0, 15);
    cycle("R5", "R9");
    idle(); rd0(2'b01, 4, 0, 4);
    cycle("R5", "R9");
    // R6: reversed run is held even over valid words
    idle(); rd0(2'b01, 4, 9, 7);
    cycle("R6", "R9");
    // R4: reserved code is held
    idle(); rd0(2'b11, 4, 6, 6);
    cycle("R4", "R9");
    // Hold releases when the missing word arrives (full 16-column run)
    idle(); wr(4, 5); rd0(2'b01, 4, 0, 15);
    cycle("R5", "R9");
    idle(); rd0(2'b01, 4, 0, 15);
    cycle("R5", "R9");

    // R7/R8: window in the bottom-right corner
    for (int r = 5; r < 8; r++)
      for (int c = 13; c < 16; c++) begin
        idle(); if (!(r == 6 && c == 14)) wr(r, c);
        cycle("R3", "R9");
      end
    idle(); rd0(2'b10, 5, 13, 0);
    cycle("R7", "R9");
    idle(); wr(6, 14); rd0(2'b10, 5, 13, 0);
    cycle("R7", "R9");
    idle(); rd0(2'b10, 5, 13, 0);
    cycle("R7", "R9");
    idle(); rd0(2'b10, 6, 13, 0);
    cycle("R8", "R9");
    idle(); rd0(2'b10, 5, 14, 0);
    cycle("R8", "R9");

    // Random mix on both ports (R9, R10)
    for (int n = 0; n < 3000; n++) begin
      idle();
      clr    = (($urandom % 300) == 0);
      wr_en  = (($urandom % 4) != 0);
      wr_row = RW'($urandom); wr_col = CW'($urandom);
      r0_req = (($urandom % 5) != 0); r0_mode = 2'($urandom);
      r0_row = RW'($urandom); r0_col = CW'($urandom); r0_stop = CW'($urandom);
      r1_req = (($urandom % 5) != 0); r1_mode = 2'($urandom);
      r1_row = RW'($urandom); r1_col = CW'($urandom); r1_stop = CW'($urandom);
      cycle(tag_of(r0_mode), "R9");
    end

    // R10: after the random mix, a final full clear leaves nothing valid
    idle(); clr = 1;
    cycle("R2", "R9");
    idle(); rd0(2'b01, 4, 0, 15); r1_req = 1; r1_mode = 2'b10;
    cycle("R2", "R2");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule